// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a SIMD floating-point unit. Software loads and stores it through a load port and a read port. A load that puts a non-zero value in any of the upper sixteen bits is refused: the block raises a general-protection fault, and the stored word stays as it was. The execution pipeline reports through an update port. Each operation it retires brings a six-bit set of detected exception conditions and a candidate single-precision result.

The block ORs the reported conditions into sticky flags. It compares them with the per-condition masks and raises a one-cycle trap when an operation detects a condition whose mask is clear. The trap comes with a vector of the conditions that caused it. When underflow is masked and flush-to-zero is on, an underflowing operation has its result replaced by a signed zero, and both the underflow and precision flags are set. The rounding-control field and the denormals-are-zero bit go straight out to the datapath.

Top module: `simd_fpcsr`

## Requirements
- R1: After a synchronous reset the read port returns 32'h0000_1F80: all six masks set, flags, denormals-are-zero, rounding control and flush-to-zero all zero.
- R2: Word layout (read back and load):
  - bits 5:0 are flags in the order invalid, denormal, divide-by-zero, overflow, underflow, precision;
  - bit 6 is denormals-are-zero;
  - bits 12:7 are the masks in the same order;
  - bits 14:13 are rounding control;
  - bit 15 is flush-to-zero.

  A flag set by an operation report stays set until a load writes it to zero.
- R3: A load with any of bits 31:16 set raises `gp_fault` for exactly the cycle after the load, and leaves the stored word unchanged.
- R4: An accepted load stores bits 15:0, visible on `rd_data` the cycle after. Bits 31:16 of `rd_data` always read zero.
- R5: A load never raises a trap, even when it clears a mask whose flag is set.
- R6: An operation whose effective conditions (as in R7) include an unmasked one raises `trap` for one cycle, the cycle after the report. `trap_vec` then equals the effective conditions AND NOT the masks, in flag order. Otherwise `trap` is 0 and `trap_vec` is zero.
- R7: An operation that reports underflow while the underflow mask (bit 11) and flush-to-zero (bit 15) are set gets `res_out` = {sign of `op_result`, 31 zeros} in the same cycle. It also gets the underflow and precision conditions added to its effective conditions.
- R8: `res_out` equals `op_result` in every other case, including underflow with the underflow mask clear, whatever the flush-to-zero bit is.
- R9: In the operation cycle that raises a trap, the effective conditions are still ORed into the flags.
- R10: When a load and an operation report arrive in the same cycle, the load wins: the operation changes no flag and raises no trap. This holds whether or not the load faults.
- R11: `rc_out` always equals bits 14:13 of the stored word, and `daz_out` equals bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Software load strobe |
| ld_data | input | 32 | Word to load |
| rd_data | output | 32 | Current register word |
| gp_fault | output | 1 | Pulse: load refused for reserved bits |
| op_valid | input | 1 | Operation report strobe |
| op_exc | input | 6 | Conditions detected, flag order |
| op_result | input | 32 | Candidate single-precision result |
| res_out | output | 32 | Result after flush substitution |
| trap | output | 1 | Pulse: unmasked condition detected |
| trap_vec | output | 6 | Unmasked conditions causing the trap |
| rc_out | output | 2 | Rounding control to datapath |
| daz_out | output | 1 | Denormals-are-zero to datapath |

## Verification
The hardest state to reach is the one where the flush, the mask and the trap logic all interact. Underflow must be masked with flush-to-zero on, while precision is unmasked. In that state a flushed result raises a precision trap that the operation never reported. Random loads rarely set exactly that combination. Directed loads therefore set up the masked-underflow cases, both with and without the precision mask. Random rounds then mix loads, including some with reserved bits, collisions between loads and reports, and random condition sets against a bench model of the word.

// File: rtl/simd_fpcsr_pkg.sv
package simd_fpcsr_pkg;

    localparam int XW = 6;   // exception condition count
    localparam int LW = 16;  // live (stored) bits of the word

    localparam int X_INV = 0;
    localparam int X_DEN = 1;
    localparam int X_DIV = 2;
    localparam int X_OVF = 3;
    localparam int X_UNF = 4;
    localparam int X_PRE = 5;

    typedef struct packed {
        logic          fz;
        logic [1:0]    rc;
        logic [XW-1:0] mask;
        logic          daz;
        logic [XW-1:0] flag;
    } csr_t;

    localparam csr_t CSR_RST = '{fz: 1'b0, rc: 2'b00, mask: {XW{1'b1}},
                                 daz: 1'b0, flag: {XW{1'b0}}};

    function automatic logic [XW-1:0] xbit(input int idx);
        logic [XW-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/fpcsr_store.sv
module fpcsr_store
    import simd_fpcsr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    input  logic          upd_en,
    input  logic [XW-1:0] upd_flags,
    output csr_t          csr,
    output logic          gp_fault
);
    localparam int RW = DW - LW;

    logic ld_bad;
    assign ld_bad = |ld_data[DW-1:LW];

    always_ff @(posedge clk) begin
        if (rst) begin
            csr      <= CSR_RST;
            gp_fault <= 1'b0;
        end else begin
            gp_fault <= ld_valid & ld_bad;
            if (ld_valid) begin
                if (!ld_bad)
                    csr <= csr_t'(ld_data[LW-1:0]);
            end else if (upd_en) begin
                csr.flag <= csr.flag | upd_flags;
            end
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> ((csr.flag & $past(csr.flag)) == $past(csr.flag))); // R2
    AST_BAD_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_bad) |=> (gp_fault && $stable(csr))); // R3
    AST_GOOD_LOAD_STORE: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_bad) |=> (!gp_fault && csr == csr_t'($past(ld_data[LW-1:0])))); // R4
    AST_NO_STRAY_FAULT: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !gp_fault); // R3

    logic [RW-1:0] unused_hi;
    assign unused_hi = '0;
endmodule

// File: rtl/fpcsr_flush.sv
module fpcsr_flush
    import simd_fpcsr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          op_valid,
    input  logic [XW-1:0] op_exc,
    input  logic [DW-1:0] op_result,
    input  csr_t          csr,
    output logic [DW-1:0] res_out,
    output logic [XW-1:0] eff_exc
);
    logic do_flush;

    always_comb begin
        do_flush = op_valid & op_exc[X_UNF] & csr.mask[X_UNF] & csr.fz;
        eff_exc  = op_exc;
        res_out  = op_result;
        if (do_flush) begin
            eff_exc = op_exc | xbit(X_UNF) | xbit(X_PRE);
            res_out = {op_result[DW-1], {(DW-1){1'b0}}};
        end
    end
endmodule

// File: rtl/fpcsr_trap.sv
module fpcsr_trap
    import simd_fpcsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_go,
    input  logic [XW-1:0] eff_exc,
    input  logic [XW-1:0] mask,
    output logic          trap,
    output logic [XW-1:0] trap_vec
);
    logic [XW-1:0] hit;
    assign hit = op_go ? (eff_exc & ~mask) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap     <= 1'b0;
            trap_vec <= '0;
        end else begin
            trap     <= |hit;
            trap_vec <= hit;
        end
    end

    AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        trap |-> (trap_vec != '0)); // R6
    AST_QUIET_VEC: assert property (@(posedge clk) disable iff (rst)
        !trap |-> (trap_vec == '0)); // R6
    AST_TRAP_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
        !op_go |=> !trap); // R10
    AST_TRAP_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
        trap |-> (($past(eff_exc) & ~$past(mask)) == trap_vec)); // R6
endmodule

// File: rtl/simd_fpcsr.sv
module simd_fpcsr
    import simd_fpcsr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] rd_data,
    output logic          gp_fault,
    input  logic          op_valid,
    input  logic [XW-1:0] op_exc,
    input  logic [DW-1:0] op_result,
    output logic [DW-1:0] res_out,
    output logic          trap,
    output logic [XW-1:0] trap_vec,
    output logic [1:0]    rc_out,
    output logic          daz_out
);
    csr_t          csr;
    logic [XW-1:0] eff_exc;
    logic          op_go;

    assign op_go = op_valid & ~ld_valid;

    fpcsr_store #(.DW(DW)) u_store (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_data(ld_data),
        .upd_en(op_go), .upd_flags(eff_exc), .csr(csr), .gp_fault(gp_fault)
    );

    fpcsr_flush #(.DW(DW)) u_flush (
        .op_valid(op_valid), .op_exc(op_exc), .op_result(op_result),
        .csr(csr), .res_out(res_out), .eff_exc(eff_exc)
    );

    fpcsr_trap u_trap (
        .clk(clk), .rst(rst), .op_go(op_go), .eff_exc(eff_exc),
        .mask(csr.mask), .trap(trap), .trap_vec(trap_vec)
    );

    assign rd_data = {{(DW-LW){1'b0}}, csr};
    assign rc_out  = csr.rc;
    assign daz_out = csr.daz;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[DW-1:LW] == '0); // R4
    AST_LOAD_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !trap); // R5
    AST_FLUSH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_exc[X_UNF] && rd_data[7+X_UNF] && rd_data[15])
        |=> (rd_data[X_UNF] && rd_data[X_PRE])); // R7
    AST_UM_CLEAR_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !rd_data[7+X_UNF]) |-> (res_out == op_result)); // R8
    AST_TRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_go && ((op_exc & ~csr.mask) != '0)) |=> ((rd_data[XW-1:0] & $past(op_exc)) == $past(op_exc))); // R9
endmodule

// File: tb/sim_simd_fpcsr.sv
`timescale 1ns/1ps
module sim_simd_fpcsr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] rd_data;
    logic        gp_fault;
    logic        op_valid = 1'b0;
    logic [5:0]  op_exc = '0;
    logic [31:0] op_result = '0;
    logic [31:0] res_out;
    logic        trap;
    logic [5:0]  trap_vec;
    logic [1:0]  rc_out;
    logic        daz_out;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m = 16'h1F80;   // bench model of the stored word

    always #4 clk = ~clk;

    simd_fpcsr u0 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_data(ld_data),
        .rd_data(rd_data), .gp_fault(gp_fault), .op_valid(op_valid),
        .op_exc(op_exc), .op_result(op_result), .res_out(res_out),
        .trap(trap), .trap_vec(trap_vec), .rc_out(rc_out), .daz_out(daz_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit flushes(input bit o, input logic [5:0] e, input logic [15:0] w);
        return o && e[4] && w[11] && w[15];
    endfunction

    task automatic step(input bit l, input logic [31:0] ld, input bit o,
                        input logic [5:0] e, input logic [31:0] r);
        bit fl;
        logic [5:0] eff, hit;
        bit bad;
        @(negedge clk);
        ld_valid = l; ld_data = ld; op_valid = o; op_exc = e; op_result = r;
        #1;
        fl = flushes(o, e, m);
        if (fl) chk("R7 result", res_out, {r[31], 31'b0});
        else    chk("R8 result", res_out, r);
        eff = fl ? (e | 6'b110000) : e;
        bad = l && (ld[31:16] != 16'h0);
        hit = (o && !l) ? (eff & ~m[12:7]) : 6'h0;
        if (l) begin
            if (!bad) m = ld[15:0];
        end else if (o) begin
            m[5:0] = m[5:0] | eff;
        end
        @(posedge clk);
        #1;
        chk(l ? "R10 word" : "R2 R9 word", rd_data, {16'h0, m});
        chk("R3 fault", {31'h0, gp_fault}, {31'h0, bad});
        chk(l ? "R5 trap" : "R6 trap", {31'h0, trap}, {31'h0, (hit != 0)});
        chk("R6 vec", {26'h0, trap_vec}, {26'h0, hit});
        chk("R11 ctl", {29'h0, daz_out, rc_out}, {29'h0, m[6], m[14:13]});
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 reset word", rd_data, 32'h0000_1F80);
        chk("R1 reset ctl", {29'h0, daz_out, rc_out}, 32'h0);
        chk("R1 reset pulses", {30'h0, trap, gp_fault}, 32'h0);
        // reserved bit load refused
        step(1, 32'h0001_0000, 0, 6'h0, 32'h0);
        step(1, 32'h8000_1F80, 0, 6'h0, 32'h0);
        // masks clear, flags set: no trap from load (R5)
        step(1, 32'h0000_003F, 0, 6'h0, 32'h0);
        step(0, 32'h0, 1, 6'h00, 32'h1234_5678);
        // clear flags, overflow unmasked -> trap, flag set (R6, R9)
        step(1, 32'h0000_0000, 0, 6'h0, 32'h0);
        step(0, 32'h0, 1, 6'b001000, 32'h7F80_0000);
        // load collides with op (R10), also with faulting load
        step(1, 32'h0000_1F80, 1, 6'b000001, 32'h1);
        step(1, 32'h0002_0000, 1, 6'b111111, 32'h1);
        // flush: underflow masked, FZ on, all masked (R7)
        step(1, 32'h0000_9F80, 0, 6'h0, 32'h0);
        step(0, 32'h0, 1, 6'b010000, 32'h8000_1234);
        step(0, 32'h0, 1, 6'b010000, 32'h0000_0042);
        // flush with precision unmasked -> precision trap (R7, R6)
        step(1, 32'h0000_8F80, 0, 6'h0, 32'h0);
        step(0, 32'h0, 1, 6'b010000, 32'h8012_3456);
        // underflow unmasked, FZ on: pass-through and trap (R8)
        step(1, 32'h0000_9780, 0, 6'h0, 32'h0);
        step(0, 32'h0, 1, 6'b010000, 32'h8000_0777);
        // FZ off, masked underflow: pass-through (R8)
        step(1, 32'h0000_1F80, 0, 6'h0, 32'h0);
        step(0, 32'h0, 1, 6'b010000, 32'h8000_0777);
        // control outputs (R11)
        step(1, 32'h0000_5FC0, 0, 6'h0, 32'h0);
        step(1, 32'h0000_3F80, 0, 6'h0, 32'h0);
        // random rounds
        for (int i = 0; i < 3000; i++) begin
            bit l, o;
            logic [31:0] d;
            l = ($urandom % 4) == 0;
            o = ($urandom % 3) != 0;
            d = {16'h0, 16'($urandom)};
            if (($urandom % 8) == 0) d[16 + ($urandom % 16)] = 1'b1;
            if (($urandom % 2) == 0) d[5:0] = 6'h0;
            step(l, d, o, 6'($urandom) & 6'($urandom), $urandom);
        end
        step(0, 32'h0, 0, 6'h0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule